// File: doc/BRIEF.md
# Dual-Slope Conversion Controller

This block is the digital half of a dual-slope analog-to-digital converter. It drives the integrator's input switch and its discharge switch, and it owns the conversion counter. A start pulse clears the counter and begins a fixed-length run-up phase with the integrator fed from the analog input. The counter wraps past its maximum, and that wrap ends the run-up. The counter then restarts from zero while the integrator runs down from the negative reference. The run-down stops when the comparator reports that the integrator output has returned to zero. The count reached at that point is proportional to the input voltage.

The comparator flag is asynchronous to the controller clock, so it passes through a two-stage synchronizer. The latency of that synchronizer is removed from the captured count. If the run-down reaches full scale before any zero crossing is seen, the conversion ends with an over-range flag and an all-ones result.

The controller has four states. `ST_IDLE` waits with the integrator shorted. `ST_INTEG` is the run-up phase. `ST_DEINT` is the run-down phase. `ST_DONE` lasts one cycle and pulses `done`. The transitions are as follows:
- IDLE→INTEG on start.
- INTEG→DEINT on counter wrap.
- DEINT→DONE on a synchronized zero crossing, or on a second counter wrap.
- DONE→IDLE unconditionally.

Top module: `dsadc_ctrl`

## Requirements
- R1: After reset, `discharge`=1, `busy`=0, `sel_ref`=0, `done`=0, `over_range`=0 and `result`=0.
- R2: A `start` pulse sampled in IDLE makes `busy`=1, `discharge`=0 and `sel_ref`=0 from the next cycle onward.
- R3: The run-up phase (`busy`=1, `sel_ref`=0) lasts exactly 2^CNT_W cycles. After that, `sel_ref`=1 and the counter restarts from zero.
- R4: Let K be the number of run-down cycles that pass before `cmp_zero` is first high. K counts from the cycle in which `sel_ref` rises, where K=0 if `cmp_zero` is high in that cycle. The captured `result` equals K. With an ideal integrator, `result` = ceil(Vin·2^CNT_W / Vref).
- R5: `done` is high for exactly one cycle per conversion. In that cycle `busy`=0, and in the next cycle the block is back in IDLE with `discharge`=1.
- R6: If K ≥ 2^CNT_W − 2, the conversion ends with `over_range`=1 and `result` all ones.
- R7: `result` and `over_range` change only in a cycle where `done`=1, and they hold their values through the following conversion until its end.
- R8: A `start` pulse while `busy`=1 has no effect. It neither restarts nor lengthens the conversion, and it does not change its result.
- R9: A high `cmp_zero` during the run-up phase is ignored, provided it falls at least two cycles before run-up ends. It neither shortens the run-up nor changes the result.
- R10: `discharge` is high exactly when the block is not busy (IDLE and DONE). `sel_ref` is high only during run-down, and never together with `discharge`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Conversion request, sampled in IDLE |
| cmp_zero | input | 1 | Asynchronous comparator flag: integrator at or below zero |
| sel_ref | output | 1 | Integrator input select: 0 = analog input, 1 = negative reference |
| discharge | output | 1 | Shorts the integrator capacitor |
| busy | output | 1 | Conversion in run-up or run-down |
| done | output | 1 | One-cycle end-of-conversion pulse |
| over_range | output | 1 | Last conversion exceeded full scale |
| result | output | CNT_W | Last conversion count |

## Verification
The bench sweeps the input across the whole range against an up/down accumulator model of the integrator. It uses several reference values, so that exact multiples and fractional quotients both occur.

- **Zero input.** With Vin=0 the comparator is already high in the first run-down cycle. An off-by-one in the latency compensation would report 1 or wrap to all ones.
- **Over-range boundary.** Inputs just below and just above 2^CNT_W−2 counts probe the limit. A design that lets the counter wrap a second time without flagging it would return a small, wrong count.
- **Busy-time stimulus.** Start pulses during a conversion would restart or stretch the run-up in a design that does not gate them. A comparator flag forced high during run-up would end the conversion early in a design that does not qualify the flag by state.
- **Result hold.** The result is also compared across the next conversion, which catches a design that clears or updates it on start.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INTEG = 2'd1,
        ST_DEINT = 2'd2,
        ST_DONE  = 2'd3
    } conv_state_t;

endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dsadc_counter.sv
module dsadc_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    output logic [CNT_W-1:0] cnt,
    output logic             at_max
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (en)  cnt <= cnt + 1'b1;
    end

    assign at_max = (cnt == CNT_MAX);
endmodule

// File: rtl/dsadc_fsm.sv
module dsadc_fsm
    import dsadc_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int LAT   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             zero_s,
    input  logic [CNT_W-1:0] cnt,
    input  logic             at_max,
    output logic             cnt_clr,
    output logic             cnt_en,
    output logic             sel_ref,
    output logic             discharge,
    output logic             busy,
    output logic             done,
    output logic             over_range,
    output logic [CNT_W-1:0] result
);
    localparam logic [CNT_W-1:0] LAT_CNT  = CNT_W'(LAT);
    localparam logic [CNT_W-1:0] FULL_CNT = '1;

    conv_state_t state, state_nx;
    logic        cap_ok, cap_ovr;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start)  state_nx = ST_INTEG;
            ST_INTEG: if (at_max) state_nx = ST_DEINT;
            ST_DEINT: if (zero_s || at_max) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs and counter controls
    always_comb begin
        cnt_clr   = 1'b0;
        cnt_en    = 1'b0;
        sel_ref   = 1'b0;
        discharge = 1'b0;
        busy      = 1'b0;
        done      = 1'b0;
        cap_ok    = 1'b0;
        cap_ovr   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                discharge = 1'b1;
                cnt_clr   = start;
            end
            ST_INTEG: begin
                busy   = 1'b1;
                cnt_en = 1'b1;
            end
            ST_DEINT: begin
                busy    = 1'b1;
                sel_ref = 1'b1;
                cap_ok  = zero_s;
                cap_ovr = !zero_s && at_max;
                cnt_en  = !zero_s && !at_max;
            end
            ST_DONE: begin
                discharge = 1'b1;
                done      = 1'b1;
            end
        endcase
    end

    // result capture, latency compensated
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result     <= '0;
            over_range <= 1'b0;
        end else if (cap_ok) begin
            result     <= (cnt >= LAT_CNT) ? cnt - LAT_CNT : '0;
            over_range <= 1'b0;
        end else if (cap_ovr) begin
            result     <= FULL_CNT;
            over_range <= 1'b1;
        end
    end
endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl #(
    parameter int CNT_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmp_zero,
    output logic             sel_ref,
    output logic             discharge,
    output logic             busy,
    output logic             done,
    output logic             over_range,
    output logic [CNT_W-1:0] result
);
    logic             zero_s;
    logic             cnt_clr, cnt_en, at_max;
    logic [CNT_W-1:0] cnt;

    dsadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cmp_zero),
        .q     (zero_s)
    );

    dsadc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .en     (cnt_en),
        .cnt    (cnt),
        .at_max (at_max)
    );

    dsadc_fsm #(.CNT_W(CNT_W), .LAT(SYNC_STAGES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .zero_s     (zero_s),
        .cnt        (cnt),
        .at_max     (at_max),
        .cnt_clr    (cnt_clr),
        .cnt_en     (cnt_en),
        .sel_ref    (sel_ref),
        .discharge  (discharge),
        .busy       (busy),
        .done       (done),
        .over_range (over_range),
        .result     (result)
    );
endmodule

// File: rtl/dsadc_ctrl_chk.sv
module dsadc_ctrl_chk #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             sel_ref,
    input logic             discharge,
    input logic             busy,
    input logic             done,
    input logic             over_range,
    input logic [CNT_W-1:0] result
);
    // R2
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R3
    ref_after_runup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_ref) |-> $past(busy) && !$past(sel_ref));

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && discharge && !busy);

    // R6
    ovr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        over_range |-> (result == {CNT_W{1'b1}}));

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result != $past(result) || over_range != $past(over_range)) |-> done);

    // R10
    sel_disch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_ref && discharge));

    // R10
    sel_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ref |-> busy);

    // R10
    disch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        discharge == !busy);
endmodule

bind dsadc_ctrl dsadc_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .sel_ref    (sel_ref),
    .discharge  (discharge),
    .busy       (busy),
    .done       (done),
    .over_range (over_range),
    .result     (result)
);

// File: tb/dsadc_ctrl_tb.sv
`timescale 1ns/1ps
module dsadc_ctrl_tb;
    localparam int W    = 6;
    localparam int FS   = 1 << W;
    localparam int FULL = FS - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         force_cmp = 1'b0;
    logic         cmp_zero;
    logic         sel_ref, discharge, busy, done, over_range;
    logic [W-1:0] result;

    int vin = 0;
    int vref = 64;
    int integ = 0;
    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    dsadc_ctrl #(.CNT_W(W), .SYNC_STAGES(2)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cmp_zero   (cmp_zero),
        .sel_ref    (sel_ref),
        .discharge  (discharge),
        .busy       (busy),
        .done       (done),
        .over_range (over_range),
        .result     (result)
    );

    // integrator model: up by vin on input, down by vref on reference
    always @(posedge clk) begin
        if (discharge)     integ <= 0;
        else if (!sel_ref) integ <= integ + vin;
        else               integ <= integ - vref;
    end
    assign cmp_zero = force_cmp || (sel_ref && integ <= 0);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic convert(input int v, input int r, input bit inject, input bit cmp_glitch);
        int n;
        int k;
        int exp_res;
        int exp_ovr;
        int prev_res;
        int prev_ovr;
        int w;
        vin = v;
        vref = r;
        prev_res = int'(result);
        prev_ovr = int'(over_range);
        k = (v * FS + r - 1) / r;
        exp_ovr = (k >= FS - 2) ? 1 : 0;
        exp_res = exp_ovr ? FULL : k;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2
        chk("R2 busy", int'(busy), 1);
        chk("R2 disch", int'(discharge), 0);
        chk("R2 sel", int'(sel_ref), 0);
        force_cmp = cmp_glitch;
        n = 0;
        while (busy && !sel_ref && n < 1000) begin
            n++;
            start = inject && (n == 10 || n == 40);
            if (n == 40) force_cmp = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        force_cmp = 1'b0;
        // R3 / R8 / R9: run-up length
        chk("R3 runup len", n, FS);
        // R7: previous result held into run-down
        chk("R7 hold res", int'(result), prev_res);
        chk("R7 hold ovr", int'(over_range), prev_ovr);
        w = 0;
        while (!done && w < 1000) begin
            w++;
            if (inject && w == 3) start = 1'b1;
            else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        // R5
        chk("R5 done", int'(done), 1);
        chk("R5 busy", int'(busy), 0);
        // R4 / R6 / R8 / R9
        chk("R4 result", int'(result), exp_res);
        chk("R6 ovr", int'(over_range), exp_ovr);
        @(negedge clk);
        chk("R5 pulse", int'(done), 0);
        chk("R10 disch", int'(discharge), 1);
        chk("R10 sel", int'(sel_ref), 0);
        repeat (3) @(negedge clk);
        chk("R7 idle hold", int'(result), exp_res);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk("R1 disch", int'(discharge), 1);
        chk("R1 busy", int'(busy), 0);
        chk("R1 sel", int'(sel_ref), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 ovr", int'(over_range), 0);
        chk("R1 result", int'(result), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 post", int'(result) + int'(busy), 0);
        // R4, R6: sweep with exact-multiple reference
        for (int v = 0; v <= 68; v++) convert(v, 64, 1'b0, 1'b0);
        // fractional quotients
        for (int v = 0; v <= 104; v += 3) convert(v, 100, 1'b0, 1'b0);
        for (int v = 1; v <= 40; v += 2) convert(v, 37, 1'b0, 1'b0);
        // R8: start pulses while busy
        convert(25, 64, 1'b1, 1'b0);
        convert(61, 64, 1'b1, 1'b0);
        // R9: comparator high during run-up
        convert(20, 64, 1'b0, 1'b1);
        convert(0, 64, 1'b0, 1'b1);
        // R6 boundary then recovery
        convert(62, 64, 1'b0, 1'b0);
        convert(5, 64, 1'b0, 1'b0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule